// File: doc/BRIEF.md
# Microcode entry-table bank selector

This block is the control register and sequencer that sits in front of the entry-table ROM of a small microcoded timer engine. The ROM carries two tables of sixteen function entries. A host writes one mode register that holds a bank choice, a halt bit and a soft-reset bit. From that register the block drives the bank in use, a run enable and a reset for the engine. It also turns each function request, a 4-bit function number, into a registered entry-table index.

The bank choice can be written once only. A soft reset is the single way to change it without a full reset. Software halts the engine and raises soft reset. It holds soft reset for a minimum number of cycles and then drops it. The engine then restarts on bank zero with the bank choice writable again. This lets a one-shot routine, such as a version query, run from one table before normal operation moves to the other. If soft reset is dropped too early, the block raises a flag.

Top module: `etab_bank_ctl`

## Requirements
- R1: After the asynchronous active-low reset, the active bank is 0, the lock is clear, halt and soft reset are 0, the early-release flag is 0, the run enable is 1 and no entry index is valid.
- R2: Mode-register write data holds the bank choice in bits [1:0], halt in bit 2 and soft reset in bit 3. A write made while unlocked and not in soft reset takes the bank choice. The value 2'b01 selects bank 1 and every other value selects bank 0. The write sets the lock in both cases.
- R3: While the lock is set, writes do not change the active bank.
- R4: The run enable is high only when halt and soft reset are both 0. Each write loads halt from bit 2.
- R5: Each write loads soft reset from bit 3. The engine reset output follows it and stays high until a write clears it. Writes made during soft reset do not take a bank choice.
- R6: The soft-reset bit is held for some number of clock edges, counted from the write that sets it (exclusive) to the write that clears it (inclusive). If it is cleared after fewer than MIN_HOLD edges (default 9), the early-release flag is set. The flag clears on the next write that raises soft reset. A hold of MIN_HOLD edges or more leaves the flag clear.
- R7: The write that ends soft reset returns the active bank to 0 and clears the lock. The next write then takes a new bank choice.
- R8: A function request that arrives while the run enable is high gives, one cycle later, a valid strobe and the index {bank, function number}. The bank in that index is the one active at the time of the request. A request made while the run enable is low gives no strobe and leaves the index unchanged.
- R9: Read data is {zeros, flag, soft reset, halt, lock, bank}, with the bank in bit 0 and the flag in bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Mode-register write strobe |
| wr_data | input | DW | Mode-register write data |
| rd_data | output | DW | Status read-back |
| fn_req | input | 1 | Function request strobe |
| fn_num | input | FN_W | Requested function number |
| bank_sel | output | 1 | Active entry-table bank |
| eng_run | output | 1 | Engine run enable |
| eng_rst | output | 1 | Engine soft reset |
| srst_err | output | 1 | Soft reset released too early |
| ent_vld | output | 1 | Entry index valid |
| ent_addr | output | FN_W+1 | Entry-table index {bank, function} |

## Verification
The bench probes the hold-time boundary by dropping soft reset after exactly MIN_HOLD edges and after one edge fewer. A counter that is off by one would flag the legal hold or miss the short one. It writes the bank choice a second time while locked, and it writes during soft reset. A design that leaves the lock open would switch banks while the engine runs. It also checks that the release write re-arms the lock, because without that the bank-one-then-bank-zero sequence could not happen. Function requests are issued just before and just after a bank change and while the engine is halted. An index built from a stale or future bank, or a strobe from a stopped engine, then shows up as a mismatch.

// File: rtl/etab_bank_ctl.sv
module etab_bank_ctl #(
  parameter int FN_W     = 4,
  parameter int DW       = 8,
  parameter int MIN_HOLD = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  input  logic            fn_req,
  input  logic [FN_W-1:0] fn_num,
  output logic            bank_sel,
  output logic            eng_run,
  output logic            eng_rst,
  output logic            srst_err,
  output logic            ent_vld,
  output logic [FN_W:0]   ent_addr
);
  localparam int CW = $clog2(MIN_HOLD + 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(MIN_HOLD - 1);

  logic          bank_q, lock_q, stop_q, srst_q, err_q;
  logic [CW-1:0] hold_cnt;
  logic          take;

  assign eng_run  = ~stop_q & ~srst_q;
  assign eng_rst  = srst_q;
  assign bank_sel = bank_q;
  assign srst_err = err_q;
  assign take     = fn_req & eng_run;
  assign rd_data  = {{(DW-5){1'b0}}, err_q, srst_q, stop_q, lock_q, bank_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q   <= 1'b0;
      lock_q   <= 1'b0;
      stop_q   <= 1'b0;
      srst_q   <= 1'b0;
      err_q    <= 1'b0;
      hold_cnt <= '0;
      ent_vld  <= 1'b0;
      ent_addr <= '0;
    end else begin
      ent_vld <= take;
      if (take) ent_addr <= {bank_q, fn_num};

      if (!srst_q)                    hold_cnt <= '0;
      else if (hold_cnt != HOLD_LAST) hold_cnt <= hold_cnt + 1'b1;

      if (wr_en) begin
        stop_q <= wr_data[2];
        srst_q <= wr_data[3];
        if (!srst_q && wr_data[3]) err_q <= 1'b0;
        if (srst_q && !wr_data[3]) begin
          bank_q <= 1'b0;
          lock_q <= 1'b0;
          if (hold_cnt != HOLD_LAST) err_q <= 1'b1;
        end else if (!srst_q && !lock_q) begin
          bank_q <= (wr_data[1:0] == 2'b01);
          lock_q <= 1'b1;
        end
      end
    end
  end

  assert_lock_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !srst_q) |=> $stable(bank_q));

  assert_release_rearms_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_rst) |-> (!bank_sel && !rd_data[1]));

  assert_no_req_in_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst |=> !ent_vld);

  assert_index_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ent_vld |-> (ent_addr[FN_W] == $past(bank_sel)));

  assert_err_on_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srst_err) |-> $fell(eng_rst));
endmodule

// File: tb/sim_etab_bank_ctl.sv
module sim_etab_bank_ctl;
  localparam int FN_W = 4, DW = 8, MIN_HOLD = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, fn_req = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [FN_W-1:0] fn_num = '0;
  logic [DW-1:0] rd_data;
  logic bank_sel, eng_run, eng_rst, srst_err, ent_vld;
  logic [FN_W:0] ent_addr;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  etab_bank_ctl #(.FN_W(FN_W), .DW(DW), .MIN_HOLD(MIN_HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .fn_req(fn_req), .fn_num(fn_num), .bank_sel(bank_sel), .eng_run(eng_run),
    .eng_rst(eng_rst), .srst_err(srst_err), .ent_vld(ent_vld), .ent_addr(ent_addr));

  always #4 clk = ~clk;

  int m_bank, m_lock, m_stop, m_srst, m_err, m_held, m_vld, m_addr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bank = 0; m_lock = 0; m_stop = 0; m_srst = 0; m_err = 0;
      m_held = 0; m_vld = 0; m_addr = 0;
    end else begin
      m_vld = (fn_req && !m_stop && !m_srst) ? 1 : 0;
      if (m_vld != 0) m_addr = m_bank * 16 + int'(fn_num);
      if (m_srst != 0) m_held = m_held + 1; else m_held = 0;
      if (wr_en) begin
        if (m_srst != 0 && !wr_data[3]) begin
          m_bank = 0; m_lock = 0;
          if (m_held < MIN_HOLD) m_err = 1;
        end else if (m_srst == 0 && m_lock == 0) begin
          m_bank = (wr_data[1:0] == 2'b01) ? 1 : 0;
          m_lock = 1;
        end
        if (m_srst == 0 && wr_data[3]) m_err = 0;
        m_stop = wr_data[2];
        m_srst = wr_data[3];
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R2 bank_sel", int'(bank_sel), m_bank);
    chk("R4 eng_run", int'(eng_run), (m_stop == 0 && m_srst == 0) ? 1 : 0);
    chk("R5 eng_rst", int'(eng_rst), m_srst);
    chk("R6 srst_err", int'(srst_err), m_err);
    chk("R8 ent_vld", int'(ent_vld), m_vld);
    chk("R8 ent_addr", int'(ent_addr), m_addr);
    chk("R9 rd_data", int'(rd_data), m_err*16 + m_srst*8 + m_stop*4 + m_lock*2 + m_bank);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp_all();
    wr_en = 1'b0;
    fn_req = 1'b0;
  endtask

  task automatic wr(input logic [3:0] v);
    wr_en = 1'b1; wr_data = {4'b0, v};
    tick();
  endtask

  task automatic req(input logic [3:0] f);
    fn_req = 1'b1; fn_num = f;
    tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic soft_reset(input int gap);
    wr(4'b1100);
    idle(gap);
    wr(4'b0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rd_data", int'(rd_data), 0);
    chk("R1 reset eng_run", int'(eng_run), 1);
    chk("R1 reset ent_vld", int'(ent_vld), 0);
    rst_n = 1'b1;
    tick();
    req(4'h3); req(4'hF); tick();
    wr(4'b0001);
    chk("R2 bank one", int'(bank_sel), 1);
    req(4'h5); tick();
    chk("R8 bank-one index", int'(ent_addr), 16 + 5);
    wr(4'b0000); wr(4'b0010);
    chk("R3 locked bank", int'(bank_sel), 1);
    wr(4'b0101);
    req(4'h7); tick();
    chk("R8 halted request", int'(ent_vld), 0);
    soft_reset(MIN_HOLD - 1);
    chk("R6 exact hold no flag", int'(srst_err), 0);
    chk("R7 bank zero after release", int'(bank_sel), 0);
    chk("R7 lock re-armed", int'(rd_data[1]), 0);
    wr(4'b0001);
    chk("R7 rewrite takes", int'(bank_sel), 1);
    req(4'hA); wr(4'b0001); req(4'hB); tick();
    wr(4'b1001); wr(4'b1000); req(4'h2);
    idle(MIN_HOLD);
    wr(4'b0000);
    chk("R5 in-reset write ignored then release", int'(bank_sel), 0);
    wr(4'b0011);
    chk("R2 value 3 maps to bank zero", int'(bank_sel), 0);
    chk("R2 value 3 locks", int'(rd_data[1]), 1);
    soft_reset(MIN_HOLD - 2);
    chk("R6 short hold flags", int'(srst_err), 1);
    wr(4'b0001); req(4'h9); tick();
    wr(4'b1000);
    chk("R6 flag clears on new soft reset", int'(srst_err), 0);
    idle(2);
    wr(4'b0000);
    chk("R6 very short hold flags", int'(srst_err), 1);
    soft_reset(MIN_HOLD + 3);
    chk("R6 long hold no flag", int'(srst_err), 0);
    wr(4'b0001); req(4'hC); req(4'h0); tick();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-run", int'(rd_data), 0);
    rst_n = 1'b1;
    tick();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule